// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software writes one 8-bit mode register. It holds a start/stop bit, a 3-bit speed code and a comparator-enable bit. From the speed code the block takes a sample length and a total conversion length, both counted in peripheral clock cycles. It holds a sample window open, then runs a binary search. Each search step drives a trial code toward the external DAC/comparator and reads back one comparator bit.

When the total length has elapsed, the block latches the search result and pulses a completion strobe. If the start bit is still set, it begins the next sample window in the same cycle. The analog multiplexer, the reference and the comparator live outside. Two speed codes are prohibited and are rejected with an error flag. A result is marked not valid when its conversion was started while the comparator was disabled.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, mode_o, result_o, result_ok_o, done_o, busy_o and err_o are all 0.
- R2: A write stores bits 7, 5, 4, 3 and 0 of wr_data into mode_o. Bits 6, 2 and 1 of mode_o always read 0. Bit 7 is start/stop, bits 5:3 are the speed code (bit 5 MSB), and bit 0 is comparator enable.
- R3: Each speed code selects a sample length S and a total length T: 000 gives 12/36, 100 gives 24/72, 110 gives 48/144, 010 gives 96/144, 101 gives 88/112, 001 gives 176/224. After a starting write, sample_o is high for the first S cycles. done_o is high in cycle T+1 counted from the write edge.
- R4: After the sample phase, the RES_W bits are decided MSB first, each in a slot of floor((T-S)/RES_W) cycles. A bit is kept when cmp_in is high at the end of its slot, with trial_o showing the bits decided so far plus the bit under test. With a threshold comparator, result_o equals the input level.
- R5: done_o is a one-cycle pulse. result_o changes only in the cycle done_o is high.
- R6: While the start bit stays 1, conversions repeat back to back, with done_o pulses exactly T cycles apart.
- R7: Every start (from idle, or a restart) records the enable bit written with it. The first result after a start with enable 0 has result_ok_o = 0. All other results have result_ok_o = 1.
- R8: A write with start = 1 and speed code 011 or 111 sets err_o, stops any conversion and starts none. mode_o bit 7 then reads 0.
- R9: A write with start = 0 makes busy_o low one cycle later, with no done_o pulse, and result_o keeps its last value.
- R10: A start write during a conversion with a different legal speed code restarts from the sample phase with the new lengths. The same code lets the running conversion finish on its original schedule.
- R11: Any write that is not a prohibited start clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| cmp_in | input | 1 | Comparator decision, high when input is at or above trial |
| mode_o | output | 8 | Stored mode register |
| sample_o | output | 1 | Sample window active |
| trial_o | output | RES_W | Trial code for the DAC |
| busy_o | output | 1 | Conversion running |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | RES_W | Last latched conversion result |
| result_ok_o | output | 1 | Latched result is valid |
| err_o | output | 1 | Last start write used a prohibited speed code |

## Verification
The bench measures sample and total lengths for every legal code against the table. A wrong table entry, or an extra register stage, would shift the strobe by whole cycles. Input levels 0 and full scale target an off-by-one in the search, which would stick or drop the MSB or the LSB. Mid-conversion writes check restart against continue and abort against completion. A design that restarted on the same code would finish late, and one that finished an aborted conversion would overwrite the held result. The disabled-comparator start checks that only the first result is flagged, not every result.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef struct packed {
      logic [7:0] smp;
      logic [7:0] tot;
      logic       legal;
   } speed_t;

   // speed code -> sample / total cycle counts
   function automatic speed_t speed_lookup(input logic [2:0] code);
      speed_t s;
      case (code)
         3'b000:  s = '{smp: 8'd12,  tot: 8'd36,  legal: 1'b1};
         3'b100:  s = '{smp: 8'd24,  tot: 8'd72,  legal: 1'b1};
         3'b110:  s = '{smp: 8'd48,  tot: 8'd144, legal: 1'b1};
         3'b010:  s = '{smp: 8'd96,  tot: 8'd144, legal: 1'b1};
         3'b101:  s = '{smp: 8'd88,  tot: 8'd112, legal: 1'b1};
         3'b001:  s = '{smp: 8'd176, tot: 8'd224, legal: 1'b1};
         default: s = '{smp: 8'd1,   tot: 8'd2,   legal: 1'b0};
      endcase
      return s;
   endfunction

   localparam int MIN_CMP_CYC = 24;  // shortest compare phase in the table

endpackage

// File: rtl/sar_timing.sv
module sar_timing
   import sar_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int CNT_W = 8
) (
   input  logic [2:0]       code,
   output logic [CNT_W-1:0] smp_len,
   output logic [CNT_W-1:0] tot_len,
   output logic [CNT_W-1:0] slot_len
);
   speed_t sp;

   always_comb begin
      sp       = speed_lookup(code);
      smp_len  = CNT_W'(sp.smp);
      tot_len  = CNT_W'(sp.tot);
      slot_len = CNT_W'((sp.tot - sp.smp) / 8'(RES_W));
   end

endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             decide,
   input  logic             cmp,
   output logic [RES_W-1:0] sar_q,
   output logic [RES_W-1:0] sar_nxt,
   output logic [RES_W-1:0] ptr_q
);
   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      localparam bit TOP = (i == RES_W - 1);
      logic ptr_in;

      if (TOP) begin : g_top
         assign ptr_in = 1'b0;
      end else begin : g_low
         assign ptr_in = ptr_q[i+1];
      end

      assign sar_nxt[i] = (decide && ptr_q[i]) ? cmp : sar_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sar_q[i] <= 1'b0;
            ptr_q[i] <= TOP;
         end else if (clear) begin
            sar_q[i] <= 1'b0;
            ptr_q[i] <= TOP;
         end else if (decide) begin
            sar_q[i] <= sar_nxt[i];
            ptr_q[i] <= ptr_in;
         end
      end
   end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
   parameter int RES_W = 10,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             kill,
   input  logic             en_new,
   input  logic             cmp_in,
   input  logic [CNT_W-1:0] smp_len,
   input  logic [CNT_W-1:0] tot_len,
   input  logic [CNT_W-1:0] slot_len,
   output logic             run_q,
   output logic             sample,
   output logic [RES_W-1:0] trial,
   output logic             done_q,
   output logic [RES_W-1:0] result_q,
   output logic             ok_q
);
   logic [CNT_W-1:0] cnt_q, slot_q;
   logic             first_q;
   logic             last, in_cmp, decide, finish;
   logic [RES_W-1:0] sar_q, sar_nxt, ptr_q;

   assign last   = run_q && (cnt_q == tot_len - 1'b1);
   assign in_cmp = run_q && (cnt_q >= smp_len) && (|ptr_q);
   assign decide = in_cmp && (slot_q == slot_len - 1'b1);
   assign finish = last && !go && !kill;
   assign sample = run_q && (cnt_q < smp_len);
   assign trial  = sar_q | ptr_q;

   sar_bits #(.RES_W(RES_W)) u_bits (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (go || kill || finish),
      .decide (decide),
      .cmp    (cmp_in),
      .sar_q  (sar_q),
      .sar_nxt(sar_nxt),
      .ptr_q  (ptr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cnt_q    <= '0;
         slot_q   <= '0;
         first_q  <= 1'b0;
         done_q   <= 1'b0;
         result_q <= '0;
         ok_q     <= 1'b0;
      end else begin
         done_q <= finish;
         if (kill) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            slot_q <= '0;
         end else if (go) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            slot_q  <= '0;
            first_q <= !en_new;
         end else if (run_q) begin
            if (last) begin
               cnt_q  <= '0;
               slot_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               if (in_cmp)
                  slot_q <= decide ? '0 : slot_q + 1'b1;
            end
         end
         if (finish) begin
            result_q <= sar_nxt;
            ok_q     <= !first_q;
            first_q  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             cmp_in,
   output logic [7:0]       mode_o,
   output logic             sample_o,
   output logic [RES_W-1:0] trial_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o,
   output logic             result_ok_o,
   output logic             err_o
);
   localparam logic [7:0] KEEP_MASK = 8'hB9;
   localparam logic [7:0] HALT_MASK = 8'h39;

   if (RES_W < 2 || RES_W > MIN_CMP_CYC) begin : g_chk_res
      $error("RES_W must lie in 2..%0d", MIN_CMP_CYC);
   end
   if (CNT_W < 8) begin : g_chk_cnt
      $error("CNT_W must hold the longest conversion");
   end

   logic [7:0]       mode_q;
   logic             err_q, run;
   logic             wr_legal, stop_req, bad_req, go_req;
   logic [CNT_W-1:0] smp_len, tot_len, slot_len;
   speed_t           wr_sp;

   always_comb begin
      wr_sp    = speed_lookup(wr_data[5:3]);
      wr_legal = wr_sp.legal;
      stop_req = wr_en && !wr_data[7];
      bad_req  = wr_en && wr_data[7] && !wr_legal;
      go_req   = wr_en && wr_data[7] && wr_legal &&
                 (!run || (wr_data[5:3] != mode_q[5:3]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         err_q  <= 1'b0;
      end else if (wr_en) begin
         mode_q <= wr_data & (bad_req ? HALT_MASK : KEEP_MASK);
         err_q  <= bad_req;
      end
   end

   sar_timing #(.RES_W(RES_W), .CNT_W(CNT_W)) u_timing (
      .code    (mode_q[5:3]),
      .smp_len (smp_len),
      .tot_len (tot_len),
      .slot_len(slot_len)
   );

   sar_ctrl #(.RES_W(RES_W), .CNT_W(CNT_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go_req),
      .kill    (stop_req || bad_req),
      .en_new  (wr_data[0]),
      .cmp_in  (cmp_in),
      .smp_len (smp_len),
      .tot_len (tot_len),
      .slot_len(slot_len),
      .run_q   (run),
      .sample  (sample_o),
      .trial   (trial_o),
      .done_q  (done_o),
      .result_q(result_o),
      .ok_q    (result_ok_o)
   );

   assign mode_o = mode_q;
   assign busy_o = run;
   assign err_o  = err_q;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic [7:0]       mode_o,
   input logic             sample_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [RES_W-1:0] result_o,
   input logic             err_o
);
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   p_sample_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> sample_o);

   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[7]) |=> (!busy_o && !done_o));

   p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7] && wr_data[4:3] == 2'b11)
         |=> (err_o && !busy_o && !mode_o[7]));

   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(wr_data[7] && wr_data[4:3] == 2'b11)) |=> !err_o);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .mode_o  (mode_o),
   .sample_o(sample_o),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .result_o(result_o),
   .err_o   (err_o)
);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [9:0] vin = '0;
   logic       cmp_in;
   logic [7:0] mode_o;
   logic       sample_o, busy_o, done_o, result_ok_o, err_o;
   logic [9:0] trial_o, result_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   assign cmp_in = (vin >= trial_o);

   sar_conv_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cmp_in(cmp_in), .mode_o(mode_o), .sample_o(sample_o),
      .trial_o(trial_o), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o), .result_ok_o(result_ok_o), .err_o(err_o)
   );

   function automatic int exp_tot(input logic [2:0] c);
      case (c)
         3'b000: return 36;  3'b100: return 72;  3'b110: return 144;
         3'b010: return 144; 3'b101: return 112; 3'b001: return 224;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_smp(input logic [2:0] c);
      case (c)
         3'b000: return 12;  3'b100: return 24;  3'b110: return 48;
         3'b010: return 96;  3'b101: return 88;  3'b001: return 176;
         default: return 0;
      endcase
   endfunction

   function automatic logic [2:0] code_of(input int k);
      case (k)
         0: return 3'b000; 1: return 3'b100; 2: return 3'b110;
         3: return 3'b010; 4: return 3'b101; default: return 3'b001;
      endcase
   endfunction

   function automatic logic [7:0] mk(input logic st, input logic [2:0] c, input logic en);
      return {st, 1'b0, c, 2'b00, en};
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // write at a negedge, count negedges until done_o, and the sample cycles seen
   task automatic run_one(input logic [7:0] d, output int n, output int ns);
      n = 0;
      ns = 0;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         wr_en = 1'b0;
         n++;
         if (done_o) break;
         if (sample_o) ns++;
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         n++;
         if (done_o) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, ns, held;
      logic [9:0] v2;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mode_o == 8'h00 && !busy_o && !done_o && !err_o, "R1 reset ctrl", int'(mode_o), 0);
      check(result_o == '0 && !result_ok_o, "R1 reset result", int'(result_o), 0);
      rst_n = 1'b1;

      // R8 prohibited code 111 with all bits set; R2 fixed bits
      wr(8'hFF);
      check(err_o && !busy_o, "R8 code 111 err", int'(err_o), 1);
      check(mode_o == 8'h39, "R2/R8 stored mode", int'(mode_o), 8'h39);
      repeat (60) @(negedge clk);
      check(!busy_o && !done_o, "R8 no conversion", int'(busy_o), 0);
      wr(mk(1'b1, 3'b011, 1'b1));
      check(err_o && !busy_o, "R8 code 011 err", int'(err_o), 1);
      // R11 clear by legal stop write, R2 storage
      wr(8'h46);
      check(!err_o, "R11 err cleared", int'(err_o), 0);
      check(mode_o == 8'h00, "R2 masked bits", int'(mode_o), 0);

      // R3/R4 each legal code, one conversion then stop
      for (int k = 0; k < 6; k++) begin
         logic [2:0] c;
         c = code_of(k);
         vin = (k == 0) ? 10'd0 : (k == 1) ? 10'd1023 : 10'($urandom);
         run_one(mk(1'b1, c, 1'b1), n, ns);
         check(n == exp_tot(c) + 1, "R3 total length", n, exp_tot(c) + 1);
         check(ns == exp_smp(c), "R3 sample length", ns, exp_smp(c));
         check(result_o == vin, "R4 result", int'(result_o), int'(vin));
         check(result_ok_o, "R7 valid with enable", int'(result_ok_o), 1);
         @(negedge clk);
         check(!done_o, "R5 one-cycle strobe", int'(done_o), 0);
         wr(mk(1'b0, c, 1'b1));
      end

      // R6/R7 continuous run started with comparator disabled
      vin = 10'd513;
      run_one(mk(1'b1, 3'b000, 1'b0), n, ns);
      check(result_ok_o == 1'b0, "R7 first result invalid", int'(result_ok_o), 0);
      check(result_o == 10'd513, "R4 result disabled start", int'(result_o), 513);
      vin = 10'd77;
      wait_done(n);
      check(n == 36, "R6 back-to-back spacing", n, 36);
      check(result_ok_o == 1'b1, "R7 second result valid", int'(result_ok_o), 1);
      check(result_o == 10'd77, "R6 second result", int'(result_o), 77);

      // R10 same code keeps schedule: still running code 000; sync to a fresh done
      wait_done(n);
      repeat (10) @(negedge clk);
      run_one(mk(1'b1, 3'b000, 1'b1), n, ns);
      check(n == 25, "R10 same code continues", n, 25);
      // R10 different code restarts
      repeat (18) @(negedge clk);
      run_one(mk(1'b1, 3'b100, 1'b1), n, ns);
      check(n == 73, "R10 code change restarts", n, 73);
      check(result_o == 10'd77, "R10 result after restart", int'(result_o), 77);

      // R9 abort holds result
      held = int'(result_o);
      vin = 10'd900;
      wr(mk(1'b1, 3'b001, 1'b1));
      repeat (30) @(negedge clk);
      wr(mk(1'b0, 3'b001, 1'b1));
      check(!busy_o, "R9 busy drops", int'(busy_o), 0);
      begin
         int seen = 0;
         for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done_o) seen++;
         end
         check(seen == 0, "R9 no strobe after stop", seen, 0);
      end
      check(int'(result_o) == held, "R9 result held", int'(result_o), held);

      // random legal codes, levels and enables
      for (int it = 0; it < 30; it++) begin
         logic [2:0] c;
         logic en;
         c = code_of(int'($urandom % 6));
         en = 1'($urandom);
         v2 = 10'($urandom);
         vin = v2;
         run_one(mk(1'b1, c, en), n, ns);
         check(n == exp_tot(c) + 1, "R3 random length", n, exp_tot(c) + 1);
         check(result_o == v2, "R4 random result", int'(result_o), int'(v2));
         check(result_ok_o == en, "R7 random valid", int'(result_ok_o), int'(en));
         wr(mk(1'b0, c, en));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule